// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

Two identical eight-line interrupt controllers are joined so that fifteen device request lines share one interrupt signal to the processor. Each controller catches rising edges into a pending register, hides lines through a mask, and picks the pending line with the smallest number. When the processor acknowledges, the controller returns a vector that is its base value plus the number of the winning line. It then moves that line from pending to in-service until software sends an end-of-interrupt command.

The secondary controller's interrupt output feeds line 2 of the primary controller, and the primary senses that line as a level. Line 2 therefore passes the secondary's requests through and never produces a vector of its own. Overall, the secondary's eight lines sit below primary lines 0 and 1 and above primary lines 3 to 7. A single write port selects the controller and the operation: mask load, base load, or end-of-interrupt.

Top module: `pic_cascade`

## Requirements
- R1: After reset the interrupt output and the vector-valid output are low, no line is pending, in service or masked, and the vector bases are 0x08 (primary) and 0x70 (secondary).
- R2: A rising edge on a request line makes that line pending. The line stays pending after the input falls, until it is acknowledged. An input that is held high does not request again.
- R3: Within one controller, a lower line number wins. Across the cascade the service order is primary 0, 1, then secondary lines 8 to 15, then primary 3 to 7. Line number n means `irq_i[n]`, with primary lines in bits 0 to 7 (bit 2 ignored) and secondary lines in bits 8 to 15.
- R4: A write with `wr_op` = 0 loads the selected controller's mask from `wr_data`, where bit k = 1 disables line k. A rising edge on a masked line is discarded. A line that is already pending is hidden while its mask bit is set and reappears when the bit is cleared.
- R5: An acknowledge that is sampled while `int_o` is high puts base + winning line number on `vec_o` and raises `vec_vld_o`, both visible after that clock edge. A write with `wr_op` = 1 loads the base from `wr_data`, and the low 3 bits are forced to zero.
- R6: An acknowledge moves the winning line from pending to in-service. The output stays low for pending lines of equal or lower priority than the highest in-service line, and a higher-priority line still raises it.
- R7: When the primary winner is line 2, the acknowledge reaches the secondary. The vector then comes from the secondary's base and line, and the primary marks line 2 in service. Primary base + 2 is never returned.
- R8: A write with `wr_op` = 2 clears the highest-priority in-service line of the selected controller. A secondary line blocks further requests until end-of-interrupt commands have reached both controllers. `wr_op` = 3 has no effect.
- R9: An acknowledge while `int_o` is low changes no state and leaves `vec_vld_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | 16 | Request lines; bits 0-7 primary (bit 2 unused), bits 8-15 secondary |
| wr_en | input | 1 | Command write strobe |
| wr_slave | input | 1 | 1 selects the secondary controller, 0 the primary |
| wr_op | input | 2 | 0 mask load, 1 base load, 2 end-of-interrupt, 3 no operation |
| wr_data | input | 8 | Mask or base value |
| ack_i | input | 1 | Processor acknowledge, one cycle |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the last acknowledged interrupt |
| vec_vld_o | output | 1 | High for the cycle after an honoured acknowledge |

## Verification
A new rising edge on a line and the acknowledge that retires the pending bit of that same line can land on one clock edge. The bench raises line 4, drops it while it is pending, and raises it again in exactly the cycle of the acknowledge. The collision is judged correct if the line stays pending. The output must drop while line 4 is in service, then return after end-of-interrupt, and a second acknowledge must return the same vector. A second collision, an end-of-interrupt in one controller while the other still holds the cascade line in service, is judged by the output staying low until both commands have arrived.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES = 8;

  typedef enum logic [1:0] {
    OP_MASK = 2'd0,
    OP_BASE = 2'd1,
    OP_EOI  = 2'd2,
    OP_NOP  = 2'd3
  } wr_op_e;
endpackage

// File: rtl/pic_rst_sync.sv
module pic_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter  int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest set index wins
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pic_unit.sv
module pic_unit
  import pic_pkg::*;
#(
  parameter  int         N        = LINES,
  parameter  bit         CASC_EN  = 1'b0,
  parameter  int         CASC_IDX = 2,
  parameter  logic [7:0] BASE_RST = 8'h08,
  localparam int         IW       = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq,
  input  logic          wr_mask,
  input  logic          wr_base,
  input  logic          wr_eoi,
  input  logic [7:0]    wr_data,
  input  logic          ack,
  output logic          int_o,
  output logic [IW-1:0] win_o,
  output logic [7:0]    vec_o
);
  // lines sensed as a level instead of through the edge register
  localparam logic [N-1:0] LVL = CASC_EN ? (N'(1) << CASC_IDX) : '0;

  logic [N-1:0]    irr_q, irr_d, isr_q, isr_d, imr_q, imr_d, prv_q;
  logic [7-IW:0]   base_q, base_d;
  logic [N-1:0]    rise, req, win_oh, eoi_oh;
  logic            req_any, isr_any, hit;
  logic [IW-1:0]   req_idx, isr_idx;

  pic_prio #(.W(N)) u_req_prio (.vec(req),   .any(req_any), .idx(req_idx));
  pic_prio #(.W(N)) u_isr_prio (.vec(isr_q), .any(isr_any), .idx(isr_idx));

  always_comb begin
    rise   = irq & ~prv_q & ~imr_q & ~LVL;
    req    = ((irr_q & ~LVL) | (irq & LVL)) & ~imr_q;
    int_o  = req_any && (!isr_any || (req_idx < isr_idx));
    hit    = ack && int_o;
    win_oh = N'(1) << req_idx;
    eoi_oh = N'(1) << isr_idx;
    irr_d  = (irr_q & ~(hit ? win_oh : '0)) | rise;
    isr_d  = (isr_q & ~((wr_eoi && isr_any) ? eoi_oh : '0)) | (hit ? win_oh : '0);
    imr_d  = wr_mask ? wr_data[N-1:0] : imr_q;
    base_d = wr_base ? wr_data[7:IW] : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      imr_q  <= '0;
      prv_q  <= '0;
      base_q <= BASE_RST[7:IW];
    end else begin
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      imr_q  <= imr_d;
      prv_q  <= irq;
      base_q <= base_d;
    end
  end

  assign win_o = req_idx;
  assign vec_o = {base_q, req_idx};

  // R2: pending bits only leave through an acknowledge
  a_r2_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ((~irr_q & $past(irr_q)) == '0));

  // R4: an edge on a masked line never becomes pending
  a_r4_masked_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr_q & ~$past(irr_q) & $past(imr_q)) == '0));

  // R6: an honoured acknowledge puts the winner in service
  a_r6_to_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_o) |=> ((isr_q & $past(win_oh)) != '0));

  // R8: end-of-interrupt retires exactly one in-service line
  a_r8_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eoi && isr_any && !ack) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
  import pic_pkg::*;
#(
  parameter  logic [7:0] M_BASE_RST = 8'h08,
  parameter  logic [7:0] S_BASE_RST = 8'h70,
  parameter  int         CASC_IDX   = 2,
  localparam int         IW         = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [2*LINES-1:0] irq_i,
  input  logic              wr_en,
  input  logic              wr_slave,
  input  logic [1:0]        wr_op,
  input  logic [7:0]        wr_data,
  input  logic              ack_i,
  output logic              int_o,
  output logic [7:0]        vec_o,
  output logic              vec_vld_o
);
  logic            rst_n;
  logic [LINES-1:0] m_irq;
  logic            m_int, s_int, s_ack;
  logic [IW-1:0]   m_win, s_win_unused;
  logic [7:0]      m_vec, s_vec, vec_d;
  logic            vld_d;
  logic            m_sel, s_sel;
  logic            unused_casc_pin;

  pic_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_ni(rst_ni), .rst_no(rst_n));

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_min
      if (g == CASC_IDX) begin : g_casc
        assign m_irq[g] = s_int;
      end else begin : g_dev
        assign m_irq[g] = irq_i[g];
      end
    end
  endgenerate
  assign unused_casc_pin = irq_i[CASC_IDX];

  assign m_sel = wr_en && !wr_slave;
  assign s_sel = wr_en &&  wr_slave;
  assign s_ack = ack_i && m_int && (m_win == IW'(CASC_IDX));

  pic_unit #(.N(LINES), .CASC_EN(1'b1), .CASC_IDX(CASC_IDX), .BASE_RST(M_BASE_RST)) u_mst (
    .clk(clk), .rst_n(rst_n), .irq(m_irq),
    .wr_mask(m_sel && wr_op == OP_MASK), .wr_base(m_sel && wr_op == OP_BASE),
    .wr_eoi(m_sel && wr_op == OP_EOI), .wr_data(wr_data), .ack(ack_i),
    .int_o(m_int), .win_o(m_win), .vec_o(m_vec));

  pic_unit #(.N(LINES), .CASC_EN(1'b0), .CASC_IDX(CASC_IDX), .BASE_RST(S_BASE_RST)) u_slv (
    .clk(clk), .rst_n(rst_n), .irq(irq_i[2*LINES-1:LINES]),
    .wr_mask(s_sel && wr_op == OP_MASK), .wr_base(s_sel && wr_op == OP_BASE),
    .wr_eoi(s_sel && wr_op == OP_EOI), .wr_data(wr_data), .ack(s_ack),
    .int_o(s_int), .win_o(s_win_unused), .vec_o(s_vec));

  always_comb begin
    vld_d = ack_i && m_int;
    vec_d = vld_d ? (s_ack ? s_vec : m_vec) : vec_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_vld_o <= 1'b0;
      vec_o     <= '0;
    end else begin
      vec_vld_o <= vld_d;
      vec_o     <= vec_d;
    end
  end

  assign int_o = m_int;

  // R7: the cascade acknowledge only reaches a secondary that is requesting
  a_r7_slave_ready: assert property (@(posedge clk) disable iff (!rst_n)
    s_ack |-> s_int);

  // R9: an acknowledge with no request produces no vector
  a_r9_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o) |=> !vec_vld_o);
endmodule

// File: tb/sim_pic_cascade.sv
module sim_pic_cascade;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq_i = '0;
  logic        wr_en = 1'b0, wr_slave = 1'b0, ack_i = 1'b0;
  logic [1:0]  wr_op = 2'd3;
  logic [7:0]  wr_data = '0;
  logic        int_o, vec_vld_o;
  logic [7:0]  vec_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pic_cascade u0 (.clk(clk), .rst_ni(rst_ni), .irq_i(irq_i), .wr_en(wr_en),
    .wr_slave(wr_slave), .wr_op(wr_op), .wr_data(wr_data), .ack_i(ack_i),
    .int_o(int_o), .vec_o(vec_o), .vec_vld_o(vec_vld_o));

  typedef struct packed {
    logic [15:0] irq; logic we; logic sl; logic [1:0] op; logic [7:0] dat;
    logic ack; logic e_int; logic e_vld; logic [7:0] e_vec; logic [3:0] rq;
  } row_t;

  localparam int NR = 54;
  localparam row_t TBL [0:NR-1] = '{
    '{16'h0000,1'b0,1'b0,2'd3,8'h00,1'b0,1'b0,1'b0,8'h00,4'd2}, // 0  idle
    '{16'h0408,1'b0,1'b0,2'd3,8'h00,1'b0,1'b1,1'b0,8'h00,4'd2}, // 1  R2 lines 3 and 10
    '{16'h0408,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b1,8'h72,4'd7}, // 2  R7 line 10 beats 3
    '{16'h0000,1'b1,1'b1,2'd2,8'h00,1'b0,1'b0,1'b0,8'h00,4'd8}, // 3  R8 slave eoi only
    '{16'h0000,1'b1,1'b0,2'd2,8'h00,1'b0,1'b1,1'b0,8'h00,4'd8}, // 4  R8 master eoi, 3 returns
    '{16'h0000,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b1,8'h0B,4'd5}, // 5  R5 vector 0x0B
    '{16'h0000,1'b1,1'b0,2'd2,8'h00,1'b0,1'b0,1'b0,8'h00,4'd8}, // 6
    '{16'h8022,1'b0,1'b0,2'd3,8'h00,1'b0,1'b1,1'b0,8'h00,4'd3}, // 7  R3 lines 1,5,15
    '{16'h8022,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b1,8'h09,4'd3}, // 8  R3 line 1 first
    '{16'h8022,1'b1,1'b0,2'd2,8'h00,1'b0,1'b1,1'b0,8'h00,4'd3}, // 9
    '{16'h8022,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b1,8'h77,4'd3}, // 10 R3 line 15 before 5
    '{16'h8022,1'b1,1'b1,2'd2,8'h00,1'b0,1'b0,1'b0,8'h00,4'd8}, // 11 R8 master 2 still busy
    '{16'h8022,1'b1,1'b0,2'd2,8'h00,1'b0,1'b1,1'b0,8'h00,4'd8}, // 12
    '{16'h8022,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b1,8'h0D,4'd3}, // 13 R3 line 5 last
    '{16'h8022,1'b1,1'b0,2'd2,8'h00,1'b0,1'b0,1'b0,8'h00,4'd2}, // 14 R2 held high no repeat
    '{16'h0000,1'b0,1'b0,2'd3,8'h00,1'b0,1'b0,1'b0,8'h00,4'd2}, // 15
    '{16'h0000,1'b1,1'b0,2'd0,8'h10,1'b0,1'b0,1'b0,8'h00,4'd4}, // 16 R4 mask line 4
    '{16'h0010,1'b0,1'b0,2'd3,8'h00,1'b0,1'b0,1'b0,8'h00,4'd4}, // 17 R4 edge discarded
    '{16'h0000,1'b1,1'b0,2'd0,8'h00,1'b0,1'b0,1'b0,8'h00,4'd4}, // 18 R4 unmask: nothing
    '{16'h0000,1'b1,1'b0,2'd1,8'h27,1'b0,1'b0,1'b0,8'h00,4'd5}, // 19 R5 base 0x27 -> 0x20
    '{16'h0040,1'b0,1'b0,2'd3,8'h00,1'b0,1'b1,1'b0,8'h00,4'd5}, // 20
    '{16'h0040,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b1,8'h26,4'd5}, // 21 R5 0x20+6
    '{16'h0000,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b0,8'h00,4'd9}, // 22 R9 idle ack
    '{16'h0000,1'b1,1'b0,2'd2,8'h00,1'b0,1'b0,1'b0,8'h00,4'd8}, // 23
    '{16'h0080,1'b0,1'b0,2'd3,8'h00,1'b0,1'b1,1'b0,8'h00,4'd4}, // 24 line 7 pending
    '{16'h0000,1'b1,1'b0,2'd0,8'h80,1'b0,1'b0,1'b0,8'h00,4'd4}, // 25 R4 hidden by mask
    '{16'h0000,1'b1,1'b0,2'd0,8'h00,1'b0,1'b1,1'b0,8'h00,4'd4}, // 26 R4 reappears
    '{16'h0000,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b1,8'h27,4'd4}, // 27
    '{16'h0000,1'b1,1'b0,2'd2,8'h00,1'b0,1'b0,1'b0,8'h00,4'd8}, // 28
    '{16'h0020,1'b0,1'b0,2'd3,8'h00,1'b0,1'b1,1'b0,8'h00,4'd6}, // 29 line 5
    '{16'h0020,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b1,8'h25,4'd6}, // 30
    '{16'h0021,1'b0,1'b0,2'd3,8'h00,1'b0,1'b1,1'b0,8'h00,4'd6}, // 31 R6 line 0 nests over 5
    '{16'h0021,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b1,8'h20,4'd6}, // 32
    '{16'h0021,1'b1,1'b0,2'd2,8'h00,1'b0,1'b0,1'b0,8'h00,4'd8}, // 33 R8 clears 0, 5 left
    '{16'h0040,1'b0,1'b0,2'd3,8'h00,1'b0,1'b0,1'b0,8'h00,4'd6}, // 34 R6 line 6 blocked by 5
    '{16'h0000,1'b1,1'b0,2'd2,8'h00,1'b0,1'b1,1'b0,8'h00,4'd8}, // 35 R8 clears 5
    '{16'h0000,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b1,8'h26,4'd6}, // 36
    '{16'h0000,1'b1,1'b0,2'd2,8'h00,1'b0,1'b0,1'b0,8'h00,4'd8}, // 37
    '{16'h0200,1'b0,1'b0,2'd3,8'h00,1'b0,1'b1,1'b0,8'h00,4'd7}, // 38 line 9
    '{16'h0200,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b1,8'h71,4'd7}, // 39
    '{16'h0300,1'b0,1'b0,2'd3,8'h00,1'b0,1'b0,1'b0,8'h00,4'd6}, // 40 R6 line 8 held by master 2
    '{16'h0300,1'b1,1'b0,2'd2,8'h00,1'b0,1'b1,1'b0,8'h00,4'd8}, // 41
    '{16'h0300,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b1,8'h70,4'd7}, // 42
    '{16'h0000,1'b1,1'b1,2'd2,8'h00,1'b0,1'b0,1'b0,8'h00,4'd8}, // 43
    '{16'h0000,1'b1,1'b1,2'd2,8'h00,1'b0,1'b0,1'b0,8'h00,4'd8}, // 44
    '{16'h0000,1'b1,1'b0,2'd2,8'h00,1'b0,1'b0,1'b0,8'h00,4'd8}, // 45
    '{16'h0000,1'b1,1'b0,2'd3,8'hFF,1'b0,1'b0,1'b0,8'h00,4'd8}, // 46 R8 op 3 no effect
    '{16'h0010,1'b0,1'b0,2'd3,8'h00,1'b0,1'b1,1'b0,8'h00,4'd2}, // 47 line 4 (mask still clear)
    '{16'h0000,1'b0,1'b0,2'd3,8'h00,1'b0,1'b1,1'b0,8'h00,4'd2}, // 48 R2 pending after fall
    '{16'h0010,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b1,8'h24,4'd2}, // 49 edge on ack edge
    '{16'h0010,1'b1,1'b0,2'd2,8'h00,1'b0,1'b1,1'b0,8'h00,4'd2}, // 50 R2 re-request kept
    '{16'h0010,1'b0,1'b0,2'd3,8'h00,1'b1,1'b0,1'b1,8'h24,4'd2}, // 51
    '{16'h0000,1'b1,1'b0,2'd2,8'h00,1'b0,1'b0,1'b0,8'h00,4'd8}, // 52
    '{16'h0000,1'b0,1'b0,2'd3,8'h00,1'b0,1'b0,1'b0,8'h00,4'd2}  // 53
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] irq, input logic we, input logic sl,
                       input logic [1:0] op, input logic [7:0] dat, input logic ack);
    @(negedge clk);
    irq_i = irq; wr_en = we; wr_slave = sl; wr_op = op; wr_data = dat; ack_i = ack;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(int_o == 1'b0, "R1", "int after reset", int_o, 0);
    chk(vec_vld_o == 1'b0, "R1", "vld after reset", vec_vld_o, 0);

    for (int i = 0; i < NR; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", TBL[i].rq, i);
      drive(TBL[i].irq, TBL[i].we, TBL[i].sl, TBL[i].op, TBL[i].dat, TBL[i].ack);
      chk(int_o == TBL[i].e_int, tag, "int", int_o, TBL[i].e_int);
      chk(vec_vld_o == TBL[i].e_vld, tag, "vld", vec_vld_o, TBL[i].e_vld);
      if (TBL[i].e_vld)
        chk(vec_o == TBL[i].e_vec, tag, "vec", vec_o, TBL[i].e_vec);
    end

    // R1: reset in the middle clears pending state and restores the base
    drive(16'h0008, 1'b0, 1'b0, 2'd3, 8'h00, 1'b0);
    chk(int_o == 1'b1, "R1", "int before reset", int_o, 1);
    @(negedge clk);
    irq_i = '0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(int_o == 1'b0, "R1", "int after second reset", int_o, 0);
    drive(16'h0008, 1'b0, 1'b0, 2'd3, 8'h00, 1'b0);
    drive(16'h0008, 1'b0, 1'b0, 2'd3, 8'h00, 1'b1);
    chk(vec_vld_o == 1'b1, "R1", "vld after reset ack", vec_vld_o, 1);
    chk(vec_o == 8'h0B, "R1", "base restored", vec_o, 8'h0B);
    drive(16'h0000, 1'b1, 1'b0, 2'd2, 8'h00, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule